// File: doc/BRIEF.md
# Packed Instruction Expander

This block sits at the front of the decode stage. Each fetched 32-bit word arrives over a valid/ready handshake. A word with an ordinary opcode is handed on unchanged. A word with one of four reserved opcodes is a pack: it names up to five entries of a 32-entry instruction table, and the block issues those entries one per cycle. An instruction may carry a 32-bit value taken from a 32-entry immediate table beside it. While a pack still has entries to issue, the block holds the fetch side off.

A pack ends early when its next index is the reserved no-op index 0. No idle cycle is spent on the no-op. A pack also ends after any instruction that is a branch. Both tables are filled through one shared write port. The opcode and the S bit of a pack decide which of its last two index fields are read as immediate-table indices and which instructions take those immediates.

Top module: `pack_expander`

## Requirements
- R1: After reset, and while no word has been accepted, `fetch_ready` is 1 and `issue_valid` and `issue_imm_valid` are 0.
- R2: A word is accepted on a rising edge where `fetch_valid` and `fetch_ready` are both 1. When bits [31:26] of the word are outside 0x38..0x3B, the word is issued unchanged in the next cycle with `issue_imm_valid` = 0.
- R3: Pack field positions: bits [31:26] opcode, [25:21] field 1, [20:16] field 2, [15:11] field 3, [10:6] field 4, [5] S, [4:0] field 5. The instruction fields issue in field order on consecutive cycles, beginning the cycle after acceptance. Each issue is the instruction-table entry at that field's index.
- R4: Index 0 is the no-op. When the next instruction field of a pack holds 0, the pack ends after the current issue. A pack whose field 1 is 0 issues nothing and leaves `fetch_ready` at 1.
- R5: An issued table instruction whose bits [31:26] lie in 0x01..0x07 is a branch, and the pack ends after it.
- R6: Opcode 0x38 uses fields 1 to 5 as instructions and carries no immediates.
- R7: Opcode 0x39 carries one immediate. With S=0, field 5 is an immediate index attached to the field-4 instruction. With S=1, field 4 is an immediate index attached to the field-3 instruction, and field 5 still issues as an instruction, without an immediate.
- R8: Opcode 0x3A issues fields 1 to 3 as instructions. Fields 4 and 5 are immediate indices. The field-5 immediate goes to the field-3 instruction. The field-4 immediate goes to the field-2 instruction when S=0 and to the field-1 instruction when S=1.
- R9: Opcode 0x3B carries one immediate on the field-1 instruction. Its index is field 4 when S=1 and field 5 when S=0. The other of those two fields issues as an instruction.
- R10: `fetch_ready` is 0 while the current pack still has instructions to issue. The next word is accepted on the edge that ends the last issue, so successive acceptances are max(issued count, 1) cycles apart.
- R11: With `tbl_we` high, `tbl_wdata` is written at `tbl_addr` into the immediate table when `tbl_sel_imm` is 1, and into the instruction table otherwise. The write is seen by issues from the next cycle on. Writes to instruction-table index 0 are ignored, so index 0 still acts as the no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetched word is present |
| fetch_word | input | 32 | Fetched word |
| fetch_ready | output | 1 | Block can take a word this cycle |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel_imm | input | 1 | 1 selects the immediate table, 0 the instruction table |
| tbl_addr | input | 5 | Table write index |
| tbl_wdata | input | 32 | Table write data |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_instr | output | 32 | Issued instruction |
| issue_imm_valid | output | 1 | `issue_imm` belongs to the issued instruction |
| issue_imm | output | 32 | Immediate value, zero when unused |

## Verification
The assertions assume `fetch_word` is steady while `fetch_valid` waits for `fetch_ready`. They also assume table writes touch only entries that no pack in flight will read. The bench meets both assumptions: it holds each word until the edge that accepts it, and it writes the tables only while the block is idle. The expected issue stream for each word is computed from a model of the two tables. Acceptance cycles are recorded so that the early-end and back-to-back timing can be compared against the issued counts.

// File: rtl/pack_expander_pkg.sv
package pack_expander_pkg;

   localparam int PACK_SLOTS = 5;

   typedef enum logic [1:0] {
      IMM_NONE    = 2'd0,
      IMM_FROM_F4 = 2'd1,
      IMM_FROM_F5 = 2'd2
   } imm_src_e;

   // per-slot plan: which fields issue as instructions, and where each one's immediate comes from
   typedef struct packed {
      logic [PACK_SLOTS-1:0]       imask;
      logic [PACK_SLOTS-1:0][1:0]  isrc;
   } slot_plan_t;

endpackage

// File: rtl/pack_table.sv
module pack_table #(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 5,
   parameter bit GUARD_ZERO = 1'b0,
   localparam int DEPTH     = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic              wr_ok;

   generate
      if (GUARD_ZERO) begin : g_guard
         assign wr_ok = we && (waddr != '0);
      end else begin : g_open
         assign wr_ok = we;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
      end else if (wr_ok) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/pack_decode.sv
module pack_decode
   import pack_expander_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 6,
   parameter int IDX_W  = 5,
   parameter logic [OPC_W-1:0] PACK_BASE = 6'h38
) (
   input  logic [WORD_W-1:0]                 word,
   output logic                              is_pack,
   output slot_plan_t                        plan,
   output logic [PACK_SLOTS-1:0][IDX_W-1:0]  flds
);

   localparam int TOP_FLD = WORD_W - OPC_W - 1;

   logic [OPC_W-1:0] opc;
   logic [1:0]       kind;
   logic             sel_s;

   assign opc     = word[WORD_W-1 -: OPC_W];
   assign is_pack = (opc[OPC_W-1:2] == PACK_BASE[OPC_W-1:2]);
   assign kind    = opc[1:0];
   assign sel_s   = word[IDX_W];

   always_comb begin
      for (int k = 0; k < PACK_SLOTS - 1; k++) flds[k] = word[TOP_FLD - k*IDX_W -: IDX_W];
      flds[PACK_SLOTS-1] = word[IDX_W-1:0];
   end

   always_comb begin
      plan.imask = '1;
      plan.isrc  = '0;
      case (kind)
         2'd1: begin
            if (!sel_s) begin
               plan.imask   = 5'b01111;
               plan.isrc[3] = IMM_FROM_F5;
            end else begin
               plan.imask   = 5'b10111;
               plan.isrc[2] = IMM_FROM_F4;
            end
         end
         2'd2: begin
            plan.imask   = 5'b00111;
            plan.isrc[2] = IMM_FROM_F5;
            if (sel_s) plan.isrc[0] = IMM_FROM_F4;
            else       plan.isrc[1] = IMM_FROM_F4;
         end
         2'd3: begin
            plan.imask   = sel_s ? 5'b10111 : 5'b01111;
            plan.isrc[0] = sel_s ? IMM_FROM_F4 : IMM_FROM_F5;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pack_sequencer.sv
module pack_sequencer
   import pack_expander_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              take_pack,
   input  logic                              take_pass,
   input  slot_plan_t                        plan,
   input  logic [PACK_SLOTS-1:0][IDX_W-1:0]  flds,
   input  logic                              cur_branch,
   output logic                              active,
   output logic                              last,
   output logic                              pass_q,
   output logic [IDX_W-1:0]                  cur_fld,
   output logic [IDX_W-1:0]                  imm_fld,
   output logic                              imm_use
);

   logic [PACK_SLOTS-1:0]             pend_q;
   logic [PACK_SLOTS-1:0][IDX_W-1:0]  fld_q;
   logic [PACK_SLOTS-1:0][1:0]        src_q;

   logic [PACK_SLOTS-1:0] cur_oh, rest, nxt_oh;
   logic [IDX_W-1:0]      nxt_fld;
   logic [1:0]            cur_src;

   always_comb begin
      cur_oh  = pend_q & (~pend_q + 1'b1);
      rest    = pend_q & ~cur_oh;
      nxt_oh  = rest & (~rest + 1'b1);
      cur_fld = '0;
      nxt_fld = '0;
      cur_src = '0;
      for (int i = 0; i < PACK_SLOTS; i++) begin
         if (cur_oh[i]) begin
            cur_fld = cur_fld | fld_q[i];
            cur_src = cur_src | src_q[i];
         end
         if (nxt_oh[i]) nxt_fld = nxt_fld | fld_q[i];
      end
   end

   assign active  = |pend_q;
   // look one field ahead so a trailing no-op costs no cycle
   assign last    = active && ((rest == '0) || (nxt_fld == '0) || cur_branch);
   assign imm_use = active && (cur_src != IMM_NONE);
   assign imm_fld = (cur_src == IMM_FROM_F4) ? fld_q[3] : fld_q[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         fld_q  <= '0;
         src_q  <= '0;
         pass_q <= 1'b0;
      end else if (take_pack) begin
         pend_q <= (flds[0] != '0) ? plan.imask : '0;
         fld_q  <= flds;
         src_q  <= plan.isrc;
         pass_q <= 1'b0;
      end else if (take_pass) begin
         pend_q <= '0;
         pass_q <= 1'b1;
      end else begin
         pass_q <= 1'b0;
         pend_q <= last ? '0 : rest;
      end
   end

endmodule

// File: rtl/pack_expander.sv
module pack_expander
   import pack_expander_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 6,
   parameter int IDX_W  = 5,
   parameter logic [OPC_W-1:0] PACK_BASE = 6'h38,
   parameter logic [OPC_W-1:0] BR_LO     = 6'h01,
   parameter logic [OPC_W-1:0] BR_HI     = 6'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [WORD_W-1:0] fetch_word,
   output logic              fetch_ready,
   input  logic              tbl_we,
   input  logic              tbl_sel_imm,
   input  logic [IDX_W-1:0]  tbl_addr,
   input  logic [WORD_W-1:0] tbl_wdata,
   output logic              issue_valid,
   output logic [WORD_W-1:0] issue_instr,
   output logic              issue_imm_valid,
   output logic [WORD_W-1:0] issue_imm
);

   initial begin : param_chk
      assert (WORD_W == OPC_W + PACK_SLOTS*IDX_W + 1) else $error("word width does not fit the pack layout");
      assert (PACK_BASE[1:0] == 2'b00) else $error("pack opcode base must be aligned to four");
      assert (BR_LO <= BR_HI) else $error("branch opcode range is empty");
   end

   logic                              dec_is_pack;
   slot_plan_t                        dec_plan;
   logic [PACK_SLOTS-1:0][IDX_W-1:0]  dec_flds;
   logic                              accept, take_pack, take_pass;
   logic                              seq_active, seq_last, seq_pass, seq_imm_use, cur_branch;
   logic [IDX_W-1:0]                  cur_fld, imm_fld;
   logic [WORD_W-1:0]                 instr_rd, imm_rd, word_q;
   logic [OPC_W-1:0]                  cur_op;

   pack_decode #(
      .WORD_W(WORD_W), .OPC_W(OPC_W), .IDX_W(IDX_W), .PACK_BASE(PACK_BASE)
   ) u_dec (
      .word(fetch_word), .is_pack(dec_is_pack), .plan(dec_plan), .flds(dec_flds)
   );

   assign fetch_ready = !seq_active || seq_last;
   assign accept      = fetch_valid && fetch_ready;
   assign take_pack   = accept && dec_is_pack;
   assign take_pass   = accept && !dec_is_pack;

   pack_sequencer #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .take_pack(take_pack), .take_pass(take_pass),
      .plan(dec_plan), .flds(dec_flds), .cur_branch(cur_branch),
      .active(seq_active), .last(seq_last), .pass_q(seq_pass),
      .cur_fld(cur_fld), .imm_fld(imm_fld), .imm_use(seq_imm_use)
   );

   pack_table #(.DATA_W(WORD_W), .IDX_W(IDX_W), .GUARD_ZERO(1'b1)) u_instr_tab (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we && !tbl_sel_imm), .waddr(tbl_addr), .wdata(tbl_wdata),
      .raddr(cur_fld), .rdata(instr_rd)
   );

   pack_table #(.DATA_W(WORD_W), .IDX_W(IDX_W), .GUARD_ZERO(1'b0)) u_imm_tab (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we && tbl_sel_imm), .waddr(tbl_addr), .wdata(tbl_wdata),
      .raddr(imm_fld), .rdata(imm_rd)
   );

   assign cur_op     = instr_rd[WORD_W-1 -: OPC_W];
   assign cur_branch = seq_active && (cur_op >= BR_LO) && (cur_op <= BR_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (take_pass) word_q <= fetch_word;
   end

   assign issue_valid     = seq_active || seq_pass;
   assign issue_instr     = seq_pass ? word_q : instr_rd;
   assign issue_imm_valid = seq_imm_use;
   assign issue_imm       = seq_imm_use ? imm_rd : '0;

endmodule

// File: rtl/pack_expander_chk.sv
module pack_expander_chk #(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 6,
   parameter int IDX_W  = 5,
   parameter logic [OPC_W-1:0] BR_LO = 6'h01,
   parameter logic [OPC_W-1:0] BR_HI = 6'h07
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic [WORD_W-1:0] fetch_word,
   input logic              fetch_ready,
   input logic              issue_valid,
   input logic [WORD_W-1:0] issue_instr,
   input logic              issue_imm_valid,
   input logic              is_pack,
   input logic              seq_pass,
   input logic [IDX_W-1:0]  cur_fld
);

   logic is_br;
   assign is_br = (issue_instr[WORD_W-1 -: OPC_W] >= BR_LO) && (issue_instr[WORD_W-1 -: OPC_W] <= BR_HI);

   assert_stall_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_ready |-> issue_valid);

   assert_stall_continues_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_ready |=> issue_valid);

   assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready && !is_pack) |=>
      (issue_valid && !issue_imm_valid && issue_instr == $past(fetch_word)));

   assert_no_nop_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !seq_pass) |-> (cur_fld != '0));

   assert_imm_in_pack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_imm_valid |-> (issue_valid && !seq_pass));

   assert_issue_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ($past(fetch_valid && fetch_ready) || $past(!fetch_ready)));

   assert_branch_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !seq_pass && is_br) |-> fetch_ready);

endmodule

bind pack_expander pack_expander_chk #(
   .WORD_W(WORD_W), .OPC_W(OPC_W), .IDX_W(IDX_W), .BR_LO(BR_LO), .BR_HI(BR_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
   .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_imm_valid(issue_imm_valid),
   .is_pack(dec_is_pack), .seq_pass(seq_pass), .cur_fld(cur_fld)
);

// File: tb/pack_expander_tb.sv
`timescale 1ns/1ps
module pack_expander_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_word = '0;
   logic        fetch_ready;
   logic        tbl_we = 1'b0;
   logic        tbl_sel_imm = 1'b0;
   logic [4:0]  tbl_addr = '0;
   logic [31:0] tbl_wdata = '0;
   logic        issue_valid;
   logic [31:0] issue_instr;
   logic        issue_imm_valid;
   logic [31:0] issue_imm;

   always #10 clk = ~clk;

   pack_expander dut_i (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
      .tbl_we(tbl_we), .tbl_sel_imm(tbl_sel_imm), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .issue_valid(issue_valid), .issue_instr(issue_instr),
      .issue_imm_valid(issue_imm_valid), .issue_imm(issue_imm)
   );

   typedef struct {
      logic [31:0] instr;
      logic        iv;
      logic [31:0] imm;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] itab_m [32];
   logic [31:0] imtab_m [32];
   int          compared = 0;
   int          mismatched = 0;
   int          cyc = 0;
   bit          done = 0;

   always @(negedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compare every issue against the scoreboard
   always @(negedge clk) begin
      if (rst_n && issue_valid) begin
         if (sb_q.size() == 0) begin
            check(0, "R3 unexpected issue", issue_instr, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(issue_instr == e.instr, {e.tag, " instr"}, issue_instr, e.instr);
            check(issue_imm_valid == e.iv, {e.tag, " imm_valid"}, issue_imm_valid, e.iv);
            if (e.iv) check(issue_imm == e.imm, {e.tag, " imm"}, issue_imm, e.imm);
         end
      end
   end

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a, b, c, d,
                                      input logic s, input logic [4:0] f);
      return {op, a, b, c, d, s, f};
   endfunction

   task automatic expect_word(input logic [31:0] w, input string tag, output int n);
      logic [5:0] op;
      logic [4:0] f[5];
      logic [4:0] mask;
      int         src[5];
      exp_t       e;
      op = w[31:26];
      f[0] = w[25:21]; f[1] = w[20:16]; f[2] = w[15:11]; f[3] = w[10:6]; f[4] = w[4:0];
      for (int i = 0; i < 5; i++) src[i] = -1;
      mask = 5'b11111;
      n = 0;
      case (op)
         6'h39: if (!w[5]) begin mask = 5'b01111; src[3] = 4; end
                else       begin mask = 5'b10111; src[2] = 3; end
         6'h3A: begin mask = 5'b00111; src[2] = 4; if (w[5]) src[0] = 3; else src[1] = 3; end
         6'h3B: begin mask = w[5] ? 5'b10111 : 5'b01111; src[0] = w[5] ? 3 : 4; end
         default: ;
      endcase
      if (op < 6'h38 || op > 6'h3B) begin
         e.instr = w; e.iv = 0; e.imm = 0; e.tag = tag;
         sb_q.push_back(e);
         n = 1;
      end else begin
         for (int i = 0; i < 5; i++) begin
            if (mask[i]) begin
               if (f[i] == 0) break;
               e.instr = itab_m[f[i]];
               e.iv    = (src[i] >= 0);
               e.imm   = (src[i] >= 0) ? imtab_m[f[src[i]]] : 32'h0;
               e.tag   = tag;
               sb_q.push_back(e);
               n++;
               if (itab_m[f[i]][31:26] >= 6'h01 && itab_m[f[i]][31:26] <= 6'h07) break;
            end
         end
      end
   endtask

   // driver: present a word, wait for acceptance, push its expected issues
   task automatic send(input logic [31:0] w, input string tag, output int acc, output int n);
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_word  = w;
      while (!fetch_ready) @(negedge clk);
      @(posedge clk);
      acc = cyc;
      expect_word(w, tag, n);
   endtask

   task automatic settle(input string tag);
      @(negedge clk);
      fetch_valid = 1'b0;
      repeat (8) @(negedge clk);
      check(sb_q.size() == 0, {tag, " all issues seen"}, sb_q.size(), 0);
   endtask

   task automatic twrite(input logic sel, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_sel_imm = sel; tbl_addr = a; tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
      if (sel) imtab_m[a] = d;
      else if (a != 0) itab_m[a] = d;
   endtask

   task automatic one(input logic [31:0] w, input string tag);
      int a, n;
      send(w, tag, a, n);
      settle(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL R10 watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int a1, a2, a3, n1, n2, n3;
      for (int i = 0; i < 32; i++) begin itab_m[i] = 0; imtab_m[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 idle state after reset
      check(fetch_ready == 1'b1, "R1 fetch_ready", fetch_ready, 1);
      check(issue_valid == 1'b0, "R1 issue_valid", issue_valid, 0);
      check(issue_imm_valid == 1'b0, "R1 issue_imm_valid", issue_imm_valid, 0);

      // R11 fill both tables
      for (int i = 1; i < 32; i++) twrite(1'b0, 5'(i), {6'h23, 5'(i), 21'(i * 13)});
      twrite(1'b0, 5'd9, {6'h04, 26'h0000123});
      twrite(1'b0, 5'd10, {6'h02, 26'h3ABCDE});
      for (int j = 0; j < 32; j++) twrite(1'b1, 5'(j), 32'hA000_0000 + j * 32'h101);
      twrite(1'b0, 5'd0, 32'hDEAD_BEEF); // R11 ignored write to index 0

      // R2 pass-through words
      one(32'h0123_4567, "R2 pass opc0");
      one(32'hFC00_0001, "R2 pass opc3F");
      one(32'h1000_00FF, "R2 pass branch-opcode");

      // R6 R3 R10 full pack, short pack, pass word back to back
      send(mk(6'h38, 1, 2, 3, 4, 0, 5), "R6 full pack", a1, n1);
      send(mk(6'h38, 6, 7, 0, 8, 0, 11), "R4 nop mid pack", a2, n2);
      send(32'h0000_0042, "R2 after packs", a3, n3);
      settle("R3 burst");
      check(n1 == 5, "R6 issued count", n1, 5);
      check(a2 - a1 == 5, "R10 gap after five", a2 - a1, 5);
      check(a3 - a2 == 2, "R10 gap after two", a3 - a2, 2);

      // R4 empty pack, R11 write to index 0 had no effect
      send(mk(6'h38, 0, 1, 2, 3, 0, 4), "R4 empty pack", a1, n1);
      send(32'h0000_0077, "R2 after empty", a2, n2);
      settle("R4 empty");
      check(n1 == 0 && a2 - a1 == 1, "R4 empty pack gap", a2 - a1, 1);
      one(mk(6'h38, 5, 0, 6, 7, 0, 8), "R11 index0 still nop");

      // R5 branches end the pack
      send(mk(6'h38, 1, 9, 3, 4, 0, 5), "R5 branch mid", a1, n1);
      send(mk(6'h38, 10, 2, 3, 4, 0, 5), "R5 branch first", a2, n2);
      send(32'h0000_0099, "R2 after branch", a3, n3);
      settle("R5 branch");
      check(a2 - a1 == 2, "R5 gap after branch", a2 - a1, 2);
      check(a3 - a2 == 1, "R5 gap branch first", a3 - a2, 1);

      // R7 R8 R9 immediate modes
      one(mk(6'h39, 1, 2, 3, 4, 0, 7), "R7 S0");
      one(mk(6'h39, 1, 2, 3, 12, 1, 6), "R7 S1");
      one(mk(6'h3A, 13, 14, 15, 20, 0, 21), "R8 S0");
      one(mk(6'h3A, 13, 14, 15, 20, 1, 21), "R8 S1");
      one(mk(6'h3B, 16, 17, 18, 19, 0, 22), "R9 S0");
      one(mk(6'h3B, 16, 17, 18, 23, 1, 24), "R9 S1");
      one(mk(6'h39, 1, 0, 3, 4, 0, 7), "R7 nop drops imm slot");

      // R11 rewritten entries seen by later packs
      twrite(1'b1, 5'd7, 32'h5555_AAAA);
      twrite(1'b0, 5'd4, 32'h8C00_1234);
      one(mk(6'h39, 1, 2, 3, 4, 0, 7), "R11 rewritten tables");

      check(sb_q.size() == 0, "R3 scoreboard empty", sb_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule